// File: doc/BRIEF.md
# Serial Double-Buffered Converter Command Front End

This block is the digital front end of a 13-bit voltage-output converter. A three-wire serial port (active-low chip select, serial clock, serial data) delivers a 16-bit command word. All three serial lines are brought into one fast system clock through synchronizers, and edge detection turns the serial clock and chip select into single-cycle events.

Nothing is acted on when the last bit arrives. When chip select returns high, the block looks at the top three bits of the word. The command can load a holding register, load the output register directly, copy the holding register into the output register, or put the converter into a low-power state and take it out again. The output register value and a shutdown flag go to the analog stage. Both registers keep their contents through shutdown, so the previous output can be recalled on exit. A frame with the wrong length is dropped, and a one-cycle error pulse reports it.

Top module: `dac_cmd_front`

## Requirements
- R1: After reset, `dac_code` is 0, `shutdown` is 0 and `frame_error` is 0. The holding register is also 0.
- R2: A frame is the bits sampled on rising serial-clock edges while `cs_n` is low, most significant bit first. Word bits [15:13] are the command and bits [12:0] are the data.
- R3: While `cs_n` is high, serial-clock and data activity changes neither the bit count nor the shift contents. The next valid frame decodes exactly as sent.
- R4: A command takes effect only after `cs_n` rises. With 16 bits shifted in and `cs_n` still low, the outputs hold their values. After the rise, the outputs change within four system clock cycles.
- R5: The bits may arrive as two groups of eight with a pause between them while `cs_n` stays low, and the frame decodes as one word.
- R6: Command 001 loads the data into the holding register only. `dac_code` and `shutdown` are unchanged.
- R7: Command 010 loads the data into both registers and clears `shutdown`.
- R8: Command 011 copies the holding register into the output register and clears `shutdown`.
- R9: Command 111 sets `shutdown` and ignores its data bits. Both registers keep their values, and later frames are still received and executed while `shutdown` is set.
- R10: Command 100 clears `shutdown` and restores the output held before shutdown. It leaves the holding register unchanged.
- R11: Commands 000, 101 and 110 change no state.
- R12: If `cs_n` rises after any bit count other than 16 (including zero), the frame is discarded with no state change, and `frame_error` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, data sampled on its rising edge |
| din | input | 1 | Serial data in |
| dac_code | output | 13 | Output register value to the converter |
| shutdown | output | 1 | Low-power state flag to the analog stage |
| frame_error | output | 1 | One-cycle pulse for a discarded frame |

## Verification
The hardest state to reach from the ports is shutdown with a holding register that differs from the output register, because that is the only case in which recall (R10) and copy (R8) give different results. The stimulus loads new holding data while shutdown is set, then issues recall first and copy later, so the two outcomes can be told apart. Malformed frames of 15, 17 and zero bits are mixed in with valid ones, and clock activity with chip select high is placed just before a valid frame. Together these show that neither the bit count nor the shift contents carry over between frames.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  localparam int DATA_W  = 13;
  localparam int CMD_W   = 3;
  localparam int FRAME_W = DATA_W + CMD_W;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP       = 3'b000,
    CMD_LOAD_HOLD = 3'b001,
    CMD_LOAD_BOTH = 3'b010,
    CMD_XFER      = 3'b011,
    CMD_WAKE      = 3'b100,
    CMD_SLEEP     = 3'b111
  } cmd_e;
endpackage

// File: rtl/serial_sync.sv
module serial_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic din,
  output logic rst_sync_n,
  output logic cs_lvl,
  output logic cs_rise,
  output logic sclk_rise,
  output logic din_lvl
);
  logic [1:0]      rst_q;
  logic [STAGES:0] cs_q, sc_q, dn_q;
  logic [STAGES:0] cs_d, sc_d, dn_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  always_comb begin
    cs_d = {cs_q[STAGES-1:0], cs_n};
    sc_d = {sc_q[STAGES-1:0], sclk};
    dn_d = {dn_q[STAGES-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cs_q <= '1;
      sc_q <= '0;
      dn_q <= '0;
    end else begin
      cs_q <= cs_d;
      sc_q <= sc_d;
      dn_q <= dn_d;
    end
  end

  assign cs_lvl    = cs_q[STAGES-1];
  assign cs_rise   = cs_q[STAGES-1] & ~cs_q[STAGES];
  assign sclk_rise = sc_q[STAGES-1] & ~sc_q[STAGES];
  assign din_lvl   = dn_q[STAGES-1];

  a_r3_rise_single: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cs_rise |=> !cs_rise);
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
  import dacif_pkg::*;
#(
  parameter int WIDTH = FRAME_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_lvl,
  input  logic             cs_rise,
  input  logic             sclk_rise,
  input  logic             din_lvl,
  output logic             frame_ok,
  output logic             frame_err,
  output logic [WIDTH-1:0] frame_word
);
  localparam int CNT_W = $clog2(WIDTH + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WIDTH);

  logic [WIDTH-1:0] shift_q, shift_d, word_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ok_q, ok_d, err_q, err_d;
  logic             shift_en;

  always_comb begin
    shift_en = !cs_lvl && sclk_rise && !cs_rise;
    shift_d  = shift_q;
    cnt_d    = cnt_q;
    if (cs_rise) begin
      cnt_d = '0;
    end else if (shift_en) begin
      shift_d = {shift_q[WIDTH-2:0], din_lvl};
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end
    ok_d  = cs_rise && (cnt_q == CNT_FULL);
    err_d = cs_rise && (cnt_q != CNT_FULL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
      word_q  <= '0;
    end else begin
      shift_q <= shift_d;
      cnt_q   <= cnt_d;
      ok_q    <= ok_d;
      err_q   <= err_d;
      if (cs_rise) word_q <= shift_q;
    end
  end

  assign frame_ok   = ok_q;
  assign frame_err  = err_q;
  assign frame_word = word_q;

  a_r3_hold_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_lvl |=> $stable(shift_q));
  a_r12_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> !err_q);
  a_r12_ok_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok_q && err_q));
endmodule

// File: rtl/cmd_regs.sv
module cmd_regs
  import dacif_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_ok,
  input  logic              frame_err,
  input  logic [DW+CMD_W-1:0] frame_word,
  output logic [DW-1:0]     out_code,
  output logic              sleep
);
  logic [DW-1:0] hold_q, hold_d, out_q, out_d;
  logic          sd_q, sd_d;
  logic          hold_en, out_en, sd_en;
  cmd_e          cmd;
  logic [DW-1:0] data;

  assign cmd  = cmd_e'(frame_word[DW+CMD_W-1:DW]);
  assign data = frame_word[DW-1:0];

  always_comb begin
    hold_en = 1'b0;
    out_en  = 1'b0;
    sd_en   = 1'b0;
    hold_d  = data;
    out_d   = data;
    sd_d    = 1'b0;
    if (frame_ok) begin
      case (cmd)
        CMD_LOAD_HOLD: hold_en = 1'b1;
        CMD_LOAD_BOTH: begin hold_en = 1'b1; out_en = 1'b1; sd_en = 1'b1; end
        CMD_XFER:      begin out_d = hold_q; out_en = 1'b1; sd_en = 1'b1; end
        CMD_WAKE:      sd_en = 1'b1;
        CMD_SLEEP:     begin sd_en = 1'b1; sd_d = 1'b1; end
        default:       ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      out_q  <= '0;
      sd_q   <= 1'b0;
    end else begin
      if (hold_en) hold_q <= hold_d;
      if (out_en)  out_q  <= out_d;
      if (sd_en)   sd_q   <= sd_d;
    end
  end

  assign out_code = out_q;
  assign sleep    = sd_q;

  a_r12_discard_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> $stable(out_q) && $stable(hold_q) && $stable(sd_q));
  a_r4_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ok |=> $stable(out_q) && $stable(hold_q) && $stable(sd_q));
  a_r6_hold_only: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && cmd == CMD_LOAD_HOLD) |=> $stable(out_q) && $stable(sd_q)
      && hold_q == $past(data));
  a_r7_load_both: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && cmd == CMD_LOAD_BOTH) |=> out_q == $past(data) && !sd_q);
  a_r9_sleep_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && cmd == CMD_SLEEP) |=> sd_q && $stable(out_q) && $stable(hold_q));
  a_r10_wake_restores: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && cmd == CMD_WAKE) |=> !sd_q && $stable(out_q) && $stable(hold_q));
endmodule

// File: rtl/dac_cmd_front.sv
module dac_cmd_front
  import dacif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  output logic [DATA_W-1:0] dac_code,
  output logic              shutdown,
  output logic              frame_error
);
  logic               rst_sync_n, cs_lvl, cs_rise, sclk_rise, din_lvl;
  logic               frame_ok, frame_err;
  logic [FRAME_W-1:0] frame_word;

  serial_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .rst_sync_n(rst_sync_n), .cs_lvl(cs_lvl), .cs_rise(cs_rise),
    .sclk_rise(sclk_rise), .din_lvl(din_lvl)
  );

  frame_shifter #(.WIDTH(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_sync_n), .cs_lvl(cs_lvl), .cs_rise(cs_rise),
    .sclk_rise(sclk_rise), .din_lvl(din_lvl), .frame_ok(frame_ok),
    .frame_err(frame_err), .frame_word(frame_word)
  );

  cmd_regs #(.DW(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .frame_ok(frame_ok), .frame_err(frame_err),
    .frame_word(frame_word), .out_code(dac_code), .sleep(shutdown)
  );

  assign frame_error = frame_err;
endmodule

// File: tb/sim_dac_cmd_front.sv
module sim_dac_cmd_front;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        din = 1'b0;
  logic [12:0] dac_code;
  logic        shutdown, frame_error;

  int checks = 0, fails = 0, cycles = 0;
  int exp_out = 0, exp_sd = 0, exp_err = 0;
  int p_out = 0, p_sd = 0, m_hold = 0;
  int err_cnt = 0, out_cnt = 0;
  bit bits_q[$];

  dac_cmd_front u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
                    .dac_code(dac_code), .shutdown(shutdown), .frame_error(frame_error));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  always @(posedge clk) begin
    #1;
    cycles++;
    if (err_cnt > 0) begin
      err_cnt--;
      exp_err = (err_cnt == 0) ? 1 : 0;
    end else exp_err = 0;
    if (out_cnt > 0) begin
      out_cnt--;
      if (out_cnt == 0) begin exp_out = p_out; exp_sd = p_sd; end
    end
    chk("R2 cycle dac_code", int'(dac_code), exp_out);
    chk("R2 cycle shutdown", int'(shutdown), exp_sd);
    chk("R12 cycle frame_error", int'(frame_error), exp_err);
    if (cycles > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic one_bit(input bit b, input bit sel);
    @(negedge clk);
    din = b; sclk = 1'b0;
    if (sel) bits_q.push_back(b);
    wait_cyc(HALF_BIT);
    sclk = 1'b1;
    wait_cyc(HALF_BIT);
    sclk = 1'b0;
  endtask

  task automatic shift_in(input logic [15:0] w, input int n, input bit pause);
    @(negedge clk);
    cs_n = 1'b0;
    wait_cyc(3);
    for (int i = 0; i < n; i++) begin
      one_bit((i < 16) ? w[15-i] : 1'b0, 1'b1);
      if (pause && i == 7) wait_cyc(20);
    end
    wait_cyc(3);
  endtask

  task automatic raise_cs();
    int w, cmd, d;
    @(negedge clk);
    cs_n = 1'b1;
    p_out = exp_out; p_sd = exp_sd;
    if (bits_q.size() != 16) begin
      err_cnt = 3;
    end else begin
      w = 0;
      foreach (bits_q[i]) w = (w << 1) | int'(bits_q[i]);
      cmd = (w >> 13) & 7;
      d = w & 16'h1FFF;
      case (cmd)
        1: m_hold = d;
        2: begin m_hold = d; p_out = d; p_sd = 0; end
        3: begin p_out = m_hold; p_sd = 0; end
        4: p_sd = 0;
        7: p_sd = 1;
        default: ;
      endcase
      out_cnt = 4;
    end
    bits_q.delete();
    wait_cyc(8);
  endtask

  task automatic frame(input int cmd, input int d, input bit pause);
    shift_in({cmd[2:0], d[12:0]}, 16, pause);
    raise_cs();
  endtask

  initial begin
    wait_cyc(5);
    chk("R1 reset dac_code", int'(dac_code), 0);
    chk("R1 reset shutdown", int'(shutdown), 0);
    chk("R1 reset frame_error", int'(frame_error), 0);
    rst_n = 1'b1;
    wait_cyc(6);

    frame(1, 13'h0ABC, 0);
    chk("R6 hold-only keeps output", int'(dac_code), 0);
    frame(3, 0, 0);
    chk("R8 copy hold to output", int'(dac_code), 13'h0ABC);
    frame(2, 13'h1555, 1);
    chk("R5 paused bursts decode", int'(dac_code), 13'h1555);
    chk("R7 load both", int'(dac_code), 13'h1555);

    shift_in({3'b010, 13'h0123}, 16, 0);
    wait_cyc(10);
    chk("R4 no effect before cs rise", int'(dac_code), 13'h1555);
    raise_cs();
    chk("R4 effect after cs rise", int'(dac_code), 13'h0123);

    for (int i = 0; i < 20; i++) one_bit(i[0], 1'b0);
    wait_cyc(6);
    chk("R3 deselected clocks ignored", int'(dac_code), 13'h0123);
    frame(1, 13'h1FFF, 0);
    chk("R3 hold-only after noise", int'(dac_code), 13'h0123);
    frame(3, 0, 0);
    chk("R3 frame intact after noise", int'(dac_code), 13'h1FFF);

    frame(7, 13'h0042, 0);
    chk("R9 shutdown set", int'(shutdown), 1);
    chk("R9 output retained", int'(dac_code), 13'h1FFF);
    frame(1, 13'h0777, 0);
    chk("R9 port active in shutdown", int'(shutdown), 1);
    chk("R9 output kept while loading", int'(dac_code), 13'h1FFF);
    frame(4, 13'h0555, 0);
    chk("R10 wake clears shutdown", int'(shutdown), 0);
    chk("R10 wake restores output", int'(dac_code), 13'h1FFF);
    frame(7, 0, 0);
    frame(3, 0, 0);
    chk("R8 copy exits shutdown", int'(shutdown), 0);
    chk("R8 copy after wake held data", int'(dac_code), 13'h0777);
    frame(7, 0, 0);
    frame(2, 13'h0333, 0);
    chk("R7 load both exits shutdown", int'(shutdown), 0);
    chk("R7 load both value", int'(dac_code), 13'h0333);

    frame(0, 13'h1111, 0);
    frame(5, 13'h1222, 0);
    frame(6, 13'h1444, 0);
    chk("R11 no-op codes output", int'(dac_code), 13'h0333);
    chk("R11 no-op codes shutdown", int'(shutdown), 0);
    frame(3, 0, 0);
    chk("R11 no-op left hold unchanged", int'(dac_code), 13'h0333);

    shift_in({3'b010, 13'h0F0F}, 15, 0);
    @(negedge clk);
    cs_n = 1'b1;
    err_cnt = 3;
    bits_q.delete();
    repeat (3) @(posedge clk);
    #2;
    chk("R12 short frame error pulse", int'(frame_error), 1);
    @(posedge clk);
    #2;
    chk("R12 error pulse one cycle", int'(frame_error), 0);
    wait_cyc(8);
    chk("R12 short frame discarded", int'(dac_code), 13'h0333);
    shift_in({3'b111, 13'h0000}, 17, 0);
    raise_cs();
    chk("R12 long frame discarded", int'(shutdown), 0);
    @(negedge clk);
    cs_n = 1'b0;
    wait_cyc(4);
    raise_cs();
    chk("R12 empty frame discarded", int'(dac_code), 13'h0333);
    frame(3, 0, 0);
    chk("R12 hold unchanged by bad frames", int'(dac_code), 13'h0333);

    wait_cyc(5);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule